// File: doc/BRIEF.md
# Buffered Page Writer with Compare Verify

This block takes a host write request (a linear byte address, a length, and a stream of data bytes) and carries it out on a page-organised serial flash that has an on-chip SRAM page buffer. It splits the request at page boundaries. For each page it issues the needed byte-level commands on a byte-exchange port, which a separate serial shifter turns into bus cycles. If the piece of the request is shorter than a page, the current page contents are first copied into the device buffer, so the bytes around the new data survive the erase-and-program. The new bytes then go through the buffer into the array. A buffer-to-array compare follows, and after each command the device status is polled until it reports ready.

A flash byte address is formed as `(page << PAGE_SHIFT) + offset`. The page size is `PAGE_BYTES` and need not be a power of two. `PAGE_SHIFT` must be at least 8, so the page number never shares the low address byte with the offset. When the request finishes, `done` pulses for one cycle. `err` then tells whether the request failed, and `written` gives the number of bytes that were programmed and verified.

Both byte ports are valid/ready channels. A byte moves on a cycle where valid and ready are both high. The flash port's `sx_ready` marks the end of one full-duplex byte exchange, and `sx_rdata` is the byte received in that exchange. The host may hold `wr_valid` low at any time, and the block simply waits. The flash side may hold `sx_ready` low for any number of cycles.

Top module: `flash_page_writer`

## Requirements
- R1: A start with length 0 gives `done` in the cycle after the start edge, with `err`=0 and `written`=0, and no byte ever handshakes on the flash port.
- R2: A start whose address plus length exceeds NUM_PAGES*PAGE_BYTES gives `done` with `err`=1 in the cycle after the start edge, and no flash port activity. A request ending exactly at the device end is accepted.
- R3: The first piece is min(length, PAGE_BYTES - offset). Each later piece is a full page, except that the last piece holds the remainder. Exactly one program command is issued per page touched.
- R4: A piece shorter than a page is preceded by a load command: byte 0x53, then the address bytes [23:16] and [15:8] of (page<<PAGE_SHIFT), then 0x00. Bytes of that page outside the piece keep their old values. A full-page piece issues no load.
- R5: Programming uses byte 0x82, then the 24-bit address (page<<PAGE_SHIFT)+offset with the most significant byte first, then the piece's data bytes in host order.
- R6: Each program is followed by a compare command: byte 0x60, the page address bytes [23:16] and [15:8], then 0x00.
- R7: After every load, program and compare, the block sends the status read 0xD7 followed by one 0x00 byte. The byte received with the 0x00 is the status. This read repeats until status bit 7 (ready) is 1, and no other command starts before that.
- R8: If the ready status after a compare has bit 6 (mismatch) set, the block issues no further command and ends with `err`=1. `written` then equals the bytes of the pages verified before that compare.
- R9: A request that completes without error ends with `written` equal to the requested length and `err`=0.
- R10: A host byte is taken only on `wr_valid && wr_ready`. Exactly `length` bytes are taken for a successful request, and gaps in `wr_valid` are tolerated.
- R11: `sx_last` marks the final byte of every command, as follows: byte 4 of a load or compare, the last data byte of a program, and the second byte of a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request (sampled when idle) |
| req_addr | input | ADDR_W | Linear byte address of the first byte |
| req_len | input | ADDR_W | Number of bytes to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Request rejected or verify mismatch; held until next start |
| written | output | ADDR_W | Bytes programmed and verified |
| wr_valid | input | 1 | Host data byte valid |
| wr_ready | output | 1 | Block accepts the host byte |
| wr_data | input | 8 | Host data byte |
| sx_valid | output | 1 | Byte to exchange on the flash port |
| sx_ready | input | 1 | Exchange finished this cycle |
| sx_data | output | 8 | Byte sent to the flash |
| sx_last | output | 1 | Last byte of the command; chip select released after it |
| sx_rdata | input | 8 | Byte received in the exchange |

## Verification
The zero-length and out-of-range results are due one cycle after the start edge. The bench therefore samples `done` and `err` at the falling edge right after it drops `start`. All other results are due at the `done` pulse, and the number of cycles to reach it depends on the stall pattern and on how many status polls the flash model answers busy. For those results the bench latches `done` at the clock edge and reads `written`, `err` and the model's command log at a later falling edge. The model answers two busy polls after each command and checks that no command starts while it is busy.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DIV, S_PLAN, S_CMD, S_DATA, S_STAT, S_FIN
  } fpw_state_t;

  typedef enum logic [1:0] {
    PH_LOAD, PH_PROG, PH_CMP
  } fpw_phase_t;

  localparam logic [7:0] OPC_LOAD   = 8'h53;
  localparam logic [7:0] OPC_PROG   = 8'h82;
  localparam logic [7:0] OPC_CMP    = 8'h60;
  localparam logic [7:0] OPC_STATUS = 8'hD7;
endpackage

// File: rtl/page_split.sv
// Sequential restoring divider: linear address -> page number and offset.
module page_split #(
  parameter int DW  = 24,
  parameter int DIV = 264,
  localparam int RB = $clog2(DIV),
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  output logic          valid,
  output logic [DW-1:0] quo,
  output logic [RB-1:0] rem
);
  logic [DW-1:0] q;
  logic [RB-1:0] r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [RB:0]   t, t_sub;
  logic          ge;

  assign t     = {r, q[DW-1]};
  assign ge    = t >= (RB+1)'(DIV);
  assign t_sub = t - (RB+1)'(DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; r <= '0; cnt <= '0; run <= 1'b0; valid <= 1'b0;
    end else if (go) begin
      q <= num; r <= '0; cnt <= '0; run <= 1'b1; valid <= 1'b0;
    end else if (run) begin
      r   <= ge ? t_sub[RB-1:0] : t[RB-1:0];
      q   <= {q[DW-2:0], ge};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(DW - 1)) begin
        run   <= 1'b0;
        valid <= 1'b1;
      end
    end else begin
      valid <= 1'b0;
    end
  end

  assign quo = q;
  assign rem = r;

  // R3: the offset handed to the sequencer lies inside a page
  p_offset_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rem < RB'(DIV)));
endmodule

// File: rtl/chunk_len.sv
// Length of the next piece: what is left, capped at the room left in the page.
module chunk_len #(
  parameter int LW         = 24,
  parameter int OW         = 9,
  parameter int PAGE_BYTES = 264
) (
  input  logic [LW-1:0] remain,
  input  logic [OW-1:0] off,
  output logic [LW-1:0] chunk,
  output logic          partial
);
  logic [LW-1:0] room;
  assign room    = LW'(PAGE_BYTES) - LW'(off);
  assign chunk   = (remain < room) ? remain : room;
  assign partial = chunk != LW'(PAGE_BYTES);
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int NUM_PAGES  = 512,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] written,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              sx_valid,
  input  logic              sx_ready,
  output logic [7:0]        sx_data,
  output logic              sx_last,
  input  logic [7:0]        sx_rdata
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(NUM_PAGES * PAGE_BYTES);

  fpw_state_t        state;
  fpw_phase_t        phase;
  logic [ADDR_W-1:0] page, remain, wrote, chunk_q, left, len_q;
  logic [OW-1:0]     off;
  logic [1:0]        idx;
  logic              err_q;

  logic              div_go, div_vld;
  logic [ADDR_W-1:0] div_q;
  logic [OW-1:0]     div_r;
  logic [ADDR_W-1:0] chunk;
  logic              partial;
  logic [ADDR_W:0]   end_pos;
  logic              over;
  logic [23:0]       page_base, full_addr, cmd_addr;
  logic [7:0]        op;
  logic              hs;
  logic              unused_status_bits;

  assign end_pos   = {1'b0, req_addr} + {1'b0, req_len};
  assign over      = end_pos > CAP;
  assign div_go    = (state == S_IDLE) && start && (req_len != '0) && !over;
  assign page_base = 24'(page) << PAGE_SHIFT;
  assign full_addr = page_base + 24'(off);
  assign cmd_addr  = (phase == PH_PROG) ? full_addr : page_base;
  assign hs        = sx_valid && sx_ready;
  assign unused_status_bits = ^sx_rdata[5:0];

  always_comb begin
    case (phase)
      PH_LOAD: op = OPC_LOAD;
      PH_PROG: op = OPC_PROG;
      default: op = OPC_CMP;
    endcase
  end

  page_split #(.DW(ADDR_W), .DIV(PAGE_BYTES)) u_split (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(req_addr),
    .valid(div_vld), .quo(div_q), .rem(div_r)
  );

  chunk_len #(.LW(ADDR_W), .OW(OW), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .remain(remain), .off(off), .chunk(chunk), .partial(partial)
  );

  // Flash-side byte mux
  always_comb begin
    sx_valid = 1'b0;
    sx_data  = 8'h00;
    sx_last  = 1'b0;
    wr_ready = 1'b0;
    case (state)
      S_CMD: begin
        sx_valid = 1'b1;
        case (idx)
          2'd0:    sx_data = op;
          2'd1:    sx_data = cmd_addr[23:16];
          2'd2:    sx_data = cmd_addr[15:8];
          default: sx_data = (phase == PH_PROG) ? cmd_addr[7:0] : 8'h00;
        endcase
        sx_last = (idx == 2'd3) && (phase != PH_PROG);
      end
      S_DATA: begin
        sx_valid = wr_valid;
        sx_data  = wr_data;
        sx_last  = left == ADDR_W'(1);
        wr_ready = sx_ready;
      end
      S_STAT: begin
        sx_valid = 1'b1;
        sx_data  = (idx == 2'd0) ? OPC_STATUS : 8'h00;
        sx_last  = idx[0];
      end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= PH_LOAD;
      page <= '0; remain <= '0; wrote <= '0; chunk_q <= '0;
      left <= '0; len_q <= '0; off <= '0; idx <= '0; err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          err_q  <= 1'b0;
          wrote  <= '0;
          len_q  <= req_len;
          remain <= req_len;
          if (req_len == '0) begin
            state <= S_FIN;
          end else if (over) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else begin
            state <= S_DIV;
          end
        end
        S_DIV: if (div_vld) begin
          page  <= div_q;
          off   <= div_r;
          state <= S_PLAN;
        end
        S_PLAN: begin
          chunk_q <= chunk;
          phase   <= partial ? PH_LOAD : PH_PROG;
          idx     <= '0;
          state   <= S_CMD;
        end
        S_CMD: if (hs) begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) begin
            if (phase == PH_PROG) begin
              left  <= chunk_q;
              state <= S_DATA;
            end else begin
              state <= S_STAT;
            end
          end
        end
        S_DATA: if (hs) begin
          left <= left - 1'b1;
          if (left == ADDR_W'(1)) begin
            idx   <= '0;
            state <= S_STAT;
          end
        end
        S_STAT: if (hs) begin
          if (idx == 2'd0) begin
            idx <= 2'd1;
          end else begin
            idx <= '0;
            if (sx_rdata[7]) begin
              case (phase)
                PH_LOAD: begin phase <= PH_PROG; state <= S_CMD; end
                PH_PROG: begin phase <= PH_CMP;  state <= S_CMD; end
                default: begin
                  if (sx_rdata[6]) begin
                    err_q <= 1'b1;
                    state <= S_FIN;
                  end else begin
                    wrote  <= wrote + chunk_q;
                    remain <= remain - chunk_q;
                    page   <= page + 1'b1;
                    off    <= '0;
                    state  <= (remain == chunk_q) ? S_FIN : S_PLAN;
                  end
                end
              endcase
            end
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = state != S_IDLE;
  assign done    = state == S_FIN;
  assign err     = err_q;
  assign written = wrote;

  // R1: empty request finishes at once without error
  p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && req_len == '0) |=> (done && !err));

  // R2: request beyond the device end is rejected at once
  p_reject_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && req_len != '0 && over) |=> (done && err));

  // R3: each planned piece is non-empty and fits in the rest of the page
  p_chunk_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PLAN) |-> (chunk != '0 &&
      chunk <= ADDR_W'(PAGE_BYTES) - ADDR_W'(off)));

  // R7: a new command only follows a status byte that reported ready
  p_cmd_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_STAT && state == S_CMD) |-> $past(sx_rdata[7]));

  // R9: the running count never exceeds the request
  p_written_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (wrote <= len_q));

  // R11: the flash port is quiet while the done pulse is up
  p_quiet_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sx_valid);
endmodule

// File: tb/sim_flash_page_writer.sv
module sim_flash_page_writer;
  localparam int PB = 12, PS = 8, NP = 8, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic busy, done, err, wr_ready, sx_valid, sx_last;
  logic [AW-1:0] written;
  logic wr_valid;
  logic [7:0] wr_data, sx_data, sx_rdata;
  logic rdy = 1'b0, gap = 1'b0;

  always #4 clk = ~clk;

  flash_page_writer #(.PAGE_BYTES(PB), .PAGE_SHIFT(PS), .NUM_PAGES(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .err(err), .written(written),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .sx_valid(sx_valid), .sx_ready(rdy), .sx_data(sx_data), .sx_last(sx_last),
    .sx_rdata(sx_rdata)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [0:NP*PB-1];
  logic [7:0] expm[0:NP*PB-1];
  logic [7:0] buff[0:PB-1];
  logic [7:0] xb  [0:31];
  logic [7:0] src [0:127];
  logic [23:0] prog_a[0:7];
  logic [7:0] load_lo;
  int xn = 0, cyc = 0, src_n = 0, src_i = 0;
  int n_load, n_prog, n_cmp, n_stat, n_bytes, seq_bad, frame_bad, bad_pg = -1;
  int busy_m = 0;
  logic mism = 1'b0, done_seen = 1'b0, done_now;

  assign sx_rdata = {busy_m == 0, mism, 6'b0};
  assign wr_valid = (src_i < src_n) && gap;
  assign wr_data  = src[src_i];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic process_cmd();
    logic [23:0] a;
    int pg, o;
    bit d;
    a  = {xb[1], xb[2], xb[3]};
    pg = int'(a >> PS);
    o  = int'(a[7:0]);
    if (xb[0] != 8'hD7 && pg >= NP) begin frame_bad++; pg = 0; end
    case (xb[0])
      8'hD7: begin
        if (xn != 2) frame_bad++;
        if (busy_m != 0) busy_m <= busy_m - 1;
        n_stat++;
      end
      8'h53: begin
        if (xn != 4) frame_bad++;
        for (int i = 0; i < PB; i++) buff[i] = mem[pg*PB + i];
        load_lo = xb[3];
        n_load++;
        busy_m <= 2;
      end
      8'h82: begin
        if (xn < 5) frame_bad++;
        if (n_prog < 8) prog_a[n_prog] = a;
        for (int i = 4; i < xn; i++) begin
          if (o + i - 4 < PB) buff[o + i - 4] = xb[i]; else frame_bad++;
        end
        for (int i = 0; i < PB; i++) mem[pg*PB + i] = buff[i];
        if (pg == bad_pg) mem[pg*PB] = mem[pg*PB] ^ 8'h01;
        n_prog++;
        busy_m <= 2;
      end
      8'h60: begin
        if (xn != 4 || xb[3] != 8'h00) frame_bad++;
        d = 1'b0;
        for (int i = 0; i < PB; i++) if (buff[i] != mem[pg*PB + i]) d = 1'b1;
        mism <= d;
        n_cmp++;
        busy_m <= 2;
      end
      default: frame_bad++;
    endcase
  endtask

  // Flash model and host byte counter
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (sx_valid && rdy) begin
      n_bytes++;
      if (xn == 0 && sx_data != 8'hD7 && busy_m != 0) seq_bad++;
      if (xn < 32) xb[xn] = sx_data;
      xn++;
      if (sx_last) begin
        process_cmd();
        xn = 0;
      end
    end
    rdy <= (cyc % 3) != 0;
    gap <= (cyc % 5) != 3;
    if (wr_valid && wr_ready) src_i <= src_i + 1;
    if (done) done_seen <= 1'b1;
  end

  task automatic run(input int addr, input int len, input int seed);
    int w;
    for (int i = 0; i < len; i++) src[i] = 8'(seed + i*13);
    n_load = 0; n_prog = 0; n_cmp = 0; n_stat = 0; n_bytes = 0;
    seq_bad = 0; frame_bad = 0; load_lo = 8'hFF;
    @(negedge clk);
    src_n = len; src_i = 0; done_seen = 1'b0;
    req_addr = AW'(addr); req_len = AW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_now = done;
    w = 0;
    while (!done_seen && w < 5000) begin @(negedge clk); w++; end
    if (!done_seen) chk(1'b0, "watchdog", w, 5000);
    @(negedge clk);
  endtask

  function automatic int mem_diff(input int lo, input int hi);
    int n = 0;
    for (int i = lo; i <= hi; i++)
      if (i >= 0 && i < NP*PB && mem[i] != expm[i]) n++;
    return n;
  endfunction

  task automatic accept(input int addr, input int len);
    for (int i = 0; i < len; i++) expm[addr + i] = src[i];
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err, "R1 reset idle", int'(busy), 0);
    chk(!sx_valid && !wr_ready, "R11 reset quiet", int'(sx_valid), 0);
    chk(written == 0, "R9 reset count", int'(written), 0);
  endtask

  task automatic t_zero();
    run(20, 0, 1);
    chk(done_now && !err, "R1 done next cycle", int'(done_now), 1);
    chk(n_bytes == 0 && written == 0, "R1 no flash bytes", n_bytes, 0);
  endtask

  task automatic t_range();
    run(85, 12, 2);
    chk(done_now && err, "R2 reject", int'(err), 1);
    chk(n_bytes == 0 && written == 0, "R2 no flash bytes", n_bytes, 0);
    run(84, 12, 3);
    accept(84, 12);
    chk(!err && written == 12, "R2 exact end accepted", int'(written), 12);
    chk(mem_diff(83, 95) == 0, "R2 end data", mem_diff(83, 95), 0);
  endtask

  task automatic t_partial();
    run(3, 5, 4);
    accept(3, 5);
    chk(n_load == 1 && load_lo == 8'h00, "R4 load issued", n_load, 1);
    chk(prog_a[0] == 24'h000003, "R5 program address", int'(prog_a[0]), 3);
    chk(mem_diff(0, 11) == 0, "R4 neighbours kept", mem_diff(0, 11), 0);
    chk(written == 5 && !err, "R9 partial count", int'(written), 5);
    chk(src_i == 5, "R10 bytes taken", src_i, 5);
  endtask

  task automatic t_span();
    run(10, 30, 5);
    accept(10, 30);
    chk(n_prog == 4 && n_cmp == 4, "R3 four pages", n_prog, 4);
    chk(n_load == 2, "R4 loads at both ends", n_load, 2);
    chk(prog_a[0] == 24'h00000A && prog_a[1] == 24'h000100 && prog_a[3] == 24'h000300,
        "R5 split addresses", int'(prog_a[1]), 256);
    chk(mem_diff(0, 47) == 0, "R3 span data", mem_diff(0, 47), 0);
    chk(n_stat == 30 && seq_bad == 0, "R7 three polls per command", n_stat, 30);
    chk(frame_bad == 0, "R11 framing", frame_bad, 0);
    chk(written == 30 && src_i == 30, "R10 span count", int'(written), 30);
  endtask

  task automatic t_full();
    run(24, 12, 6);
    accept(24, 12);
    chk(n_load == 0 && n_prog == 1 && n_cmp == 1, "R6 full page no load", n_load, 0);
    chk(mem_diff(23, 36) == 0 && written == 12, "R9 full page", mem_diff(23, 36), 0);
  endtask

  task automatic t_mismatch();
    bad_pg = 1;
    run(0, 30, 7);
    bad_pg = -1;
    chk(err == 1'b1, "R8 error flag", int'(err), 1);
    chk(written == 12, "R8 bytes before fault", int'(written), 12);
    chk(n_prog == 2 && n_cmp == 2, "R8 stop after compare", n_prog, 2);
    accept(0, 12);
    chk(mem_diff(0, 11) == 0, "R8 first page kept", mem_diff(0, 11), 0);
  endtask

  initial begin
    for (int i = 0; i < NP*PB; i++) begin
      mem[i]  = 8'(i*7 + 3);
      expm[i] = 8'(i*7 + 3);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zero();
    t_range();
    t_partial();
    t_span();
    t_full();
    t_mismatch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    chk(1'b0, "global watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule